// File: doc/BRIEF.md
# Word-Wide Shift Register Chain

This block is a chain of N stages, each holding a W-bit word. On each active clock edge the chain does one of three things. It can shift: every word moves one stage older and a new serial word enters the youngest stage. It can parallel-load: every stage is written at once from its own input word. Or it can hold all stages as they are.

A parameter picks whether the rising or the falling clock edge is active. A second parameter turns on parallel access, which enables the load control, the per-stage load words and the per-stage read-out. An asynchronous clear forces every stage to zero at once, whatever the clock is doing. The oldest stage's word always drives the serial output, so the block can serve as a word delay line or as a serial-to-parallel and parallel-to-serial converter.

Top module: `shreg_word_chain`

## Requirements
- R1: While `clr` is 1, every stage reads as zero right away, with no clock edge needed. Clock edges that occur while `clr` is 1 change nothing, whatever `shift_en`, `load`, `sin` and `par_d` are.
- R2: At an active edge with `shift_en`=1 and no parallel load, stage k (k>0) takes the word stage k-1 held before the edge, and stage 0 takes `sin`.
- R3: At an active edge with `shift_en`=0 and no parallel load, every stage keeps its word.
- R4: At an active edge with `load`=1 and parallel access enabled, every stage is written from `par_d` and `shift_en` has no effect in that cycle.
- R5: Stage i uses bits [i*W +: W] of both `par_d` and `par_q`. Stage 0, in the lowest bits, is the youngest, and stage N-1 is the oldest.
- R6: `sout` always equals the word in the oldest stage, N-1.
- R7: With RISE_EDGE=1 the stages update only on rising clock edges. With RISE_EDGE=0 they update only on falling edges.
- R8: With PAR_EN=0, `load` and `par_d` have no effect and `par_q` reads as all zeros.
- R9: With N=1, a shift replaces the single stage with `sin`, and `sout` shows it after that edge.
- R10: After `clr` falls, the first change to the stages happens at the next active edge and follows the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is chosen by RISE_EDGE |
| clr | input | 1 | Asynchronous clear, active high |
| shift_en | input | 1 | Shift enable, sampled at the active edge |
| load | input | 1 | Parallel load request; takes priority over shift |
| sin | input | W | Serial word that enters stage 0 on a shift |
| par_d | input | N*W | Parallel load words, stage i in bits [i*W +: W] |
| par_q | output | N*W | Per-stage contents, stage i in bits [i*W +: W]; zero when PAR_EN=0 |
| sout | output | W | Word held in the oldest stage |

## Verification
On every active edge, the embedded assertions check four things: each stage moves to the next older stage on a shift, every stage holds when idle, a parallel load wins over shift, and the stages read zero whenever the clear is high. Some behaviours cannot be seen from a single edge, so only the bench scenarios show them. These are the immediate, edge-free effect of a clear raised between edges, the choice of active edge (checked on two instances updating on opposite edges), the N=1 chain with parallel access disabled, and the first update after the clear is released.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } stage_op_e;

    // Load outranks shift; load only counts when parallel access exists.
    function automatic stage_op_e pick_op(input logic shift_en,
                                          input logic load,
                                          input bit   par_en);
        if (par_en && load)
            return OP_LOAD;
        else if (shift_en)
            return OP_SHIFT;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
    import shreg_pkg::*;
#(
    parameter bit PAR_EN = 1'b1
) (
    input  logic      shift_en,
    input  logic      load,
    output stage_op_e op
);

    always_comb op = pick_op(shift_en, load, PAR_EN);

endmodule

// File: rtl/shreg_stage.sv
module shreg_stage
    import shreg_pkg::*;
#(
    parameter int W         = 8,
    parameter bit RISE_EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         clr,
    input  stage_op_e    op,
    input  logic [W-1:0] shift_in,
    input  logic [W-1:0] load_in,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    always_comb begin
        case (op)
            OP_SHIFT: nxt = shift_in;
            OP_LOAD:  nxt = load_in;
            default:  nxt = q;
        endcase
    end

    generate
        if (RISE_EDGE) begin : g_rise
            always_ff @(posedge clk or posedge clr) begin
                if (clr) q <= '0;
                else     q <= nxt;
            end
        end else begin : g_fall
            always_ff @(negedge clk or posedge clr) begin
                if (clr) q <= '0;
                else     q <= nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/shreg_word_chain.sv
module shreg_word_chain
    import shreg_pkg::*;
#(
    parameter int W         = 8,
    parameter int N         = 4,
    parameter bit PAR_EN    = 1'b1,
    parameter bit RISE_EDGE = 1'b1
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           shift_en,
    input  logic           load,
    input  logic [W-1:0]   sin,
    input  logic [N*W-1:0] par_d,
    output logic [N*W-1:0] par_q,
    output logic [W-1:0]   sout
);

    localparam int TOTAL = N * W;

    stage_op_e    op;
    logic [W-1:0] stg     [N];
    logic [W-1:0] feed    [N];
    logic [W-1:0] ld_word [N];
    logic [TOTAL-1:0] flat;

    shreg_ctrl #(.PAR_EN(PAR_EN)) u_ctrl (
        .shift_en (shift_en),
        .load     (load),
        .op       (op)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign feed[i] = sin;
            end else begin : g_body
                assign feed[i] = stg[i-1];
            end

            if (PAR_EN) begin : g_ld
                assign ld_word[i] = par_d[i*W +: W];
            end else begin : g_nold
                assign ld_word[i] = '0;
            end

            shreg_stage #(.W(W), .RISE_EDGE(RISE_EDGE)) u_stage (
                .clk      (clk),
                .clr      (clr),
                .op       (op),
                .shift_in (feed[i]),
                .load_in  (ld_word[i]),
                .q        (stg[i])
            );

            assign flat[i*W +: W] = stg[i];
        end

        if (PAR_EN) begin : g_pq
            assign par_q = flat;
        end else begin : g_nopq
            assign par_q = '0;
        end
    endgenerate

    assign sout = stg[N-1];

    // Assertions, sampled on the active edge
    logic clk_act;
    assign clk_act = RISE_EDGE ? clk : ~clk;

    // R1: clear pins every stage at zero
    a_r1_clear_zero: assert property (@(posedge clk_act)
        clr |-> (flat == '0));

    // R3: idle edge keeps all stages
    a_r3_hold_all: assert property (@(posedge clk_act) disable iff (clr)
        (op == OP_HOLD) |=> (flat == $past(flat)));

    // R2: serial word enters the youngest stage
    a_r2_head_takes_sin: assert property (@(posedge clk_act) disable iff (clr)
        (op == OP_SHIFT) |=> (stg[0] == $past(sin)));

    generate
        for (genvar k = 1; k < N; k++) begin : g_chk
            // R2: each stage takes the next younger word
            a_r2_stage_moves: assert property (@(posedge clk_act) disable iff (clr)
                (op == OP_SHIFT) |=> (stg[k] == $past(stg[k-1])));
        end

        if (PAR_EN) begin : g_chk_ld
            // R4: load wins over shift and writes every stage
            a_r4_load_wins: assert property (@(posedge clk_act) disable iff (clr)
                (load && shift_en) |=> (flat == $past(par_d)));
        end
    endgenerate

endmodule

// File: tb/sim_shreg_word_chain.sv
module sim_shreg_word_chain;

    localparam int W0 = 8;
    localparam int N0 = 4;
    localparam int W1 = 4;
    localparam int N1 = 1;
    localparam time HALF = 4ns;

    logic clk = 1'b0;
    logic clr = 1'b1;

    logic              sh0 = 1'b0, ld0 = 1'b0;
    logic [W0-1:0]     si0 = '0;
    logic [N0*W0-1:0]  pd0 = '0;
    logic [N0*W0-1:0]  pq0;
    logic [W0-1:0]     so0;

    logic              sh1 = 1'b0, ld1 = 1'b0;
    logic [W1-1:0]     si1 = '0;
    logic [N1*W1-1:0]  pd1 = '0;
    logic [N1*W1-1:0]  pq1;
    logic [W1-1:0]     so1;

    int nchk  = 0;
    int nfail = 0;
    logic [W0-1:0] m0 [N0];
    logic [W1-1:0] m1;

    always #HALF clk = ~clk;

    shreg_word_chain #(.W(W0), .N(N0), .PAR_EN(1'b1), .RISE_EDGE(1'b1)) u0 (
        .clk(clk), .clr(clr), .shift_en(sh0), .load(ld0),
        .sin(si0), .par_d(pd0), .par_q(pq0), .sout(so0)
    );

    shreg_word_chain #(.W(W1), .N(N1), .PAR_EN(1'b0), .RISE_EDGE(1'b0)) u1 (
        .clk(clk), .clr(clr), .shift_en(sh1), .load(ld1),
        .sin(si1), .par_d(pd1), .par_q(pq1), .sout(so1)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_u0(input string req);
        for (int i = 0; i < N0; i++)
            chk({req, " R5 stage slice"}, 64'(pq0[i*W0 +: W0]), 64'(m0[i]));
        chk("R6 sout oldest", 64'(so0), 64'(m0[N0-1]));
    endtask

    task automatic check_u1(input string req);
        chk({req, " R9 single stage"}, 64'(so1), 64'(m1));
        chk("R8 par_q zero", 64'(pq1), 64'd0);
    endtask

    // One full clock: u0 is checked just after the rising edge and driven
    // after the falling edge; u1 (falling-edge) the other way round (R7).
    task automatic step(input string req,
                        input logic s0, input logic l0, input logic [W0-1:0] d0,
                        input logic [N0*W0-1:0] p0,
                        input logic s1, input logic l1, input logic [W1-1:0] d1);
        @(posedge clk); #1;
        check_u0(req);
        sh1 = s1; ld1 = l1; si1 = d1; pd1 = ~d1;
        if (s1) m1 = d1;
        @(negedge clk); #1;
        check_u1({req, " R7"});
        sh0 = s0; ld0 = l0; si0 = d0; pd0 = p0;
        if (l0) begin
            for (int i = 0; i < N0; i++) m0[i] = p0[i*W0 +: W0];
        end else if (s0) begin
            for (int i = N0-1; i > 0; i--) m0[i] = m0[i-1];
            m0[0] = d0;
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        #1;
        for (int i = 0; i < N0; i++) m0[i] = '0;
        m1 = '0;
        chk("R1 immediate clear u0", 64'(pq0), 64'd0);
        chk("R1 immediate clear u1", 64'(so1), 64'd0);
        sh0 = 1'b1; ld0 = 1'b1; pd0 = 32'hFFFF_FFFF; sh1 = 1'b1; si1 = 4'hF;
        @(posedge clk); #1;
        chk("R1 edge ignored u0", 64'(pq0), 64'd0);
        @(negedge clk); #1;
        chk("R1 edge ignored u1", 64'(so1), 64'd0);
        sh0 = 1'b0; ld0 = 1'b0; sh1 = 1'b0;
        clr = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N0; i++) m0[i] = '0;
        m1 = '0;
        #3;
        chk("R1 reset u0", 64'(pq0), 64'd0);
        chk("R1 reset sout", 64'(so0), 64'd0);
        chk("R1 reset u1", 64'(so1), 64'd0);
        @(negedge clk); #1;
        clr = 1'b0;

        // R2: shift in distinct words
        step("R2", 1, 0, 8'h11, '0, 1, 0, 4'h3);
        step("R2", 1, 0, 8'h22, '0, 1, 0, 4'h5);
        step("R2", 1, 0, 8'h33, '0, 0, 0, 4'h9);
        step("R2", 1, 0, 8'h44, '0, 1, 0, 4'hA);
        step("R2", 1, 0, 8'h55, '0, 1, 1, 4'hC);
        // R3: hold
        step("R3", 0, 0, 8'hEE, 32'hDEAD_BEEF, 0, 1, 4'h7);
        step("R3", 0, 0, 8'hEF, '0, 0, 0, 4'h1);
        step("R3", 0, 0, 8'hF0, '0, 1, 0, 4'h6);
        // R4: load with shift high, then with shift low
        step("R4", 1, 1, 8'h99, 32'hA1B2_C3D4, 1, 0, 4'h2);
        step("R6", 1, 0, 8'h07, '0, 0, 0, 4'h0);
        step("R6", 1, 0, 8'h08, '0, 1, 0, 4'hE);
        step("R4", 0, 1, 8'h66, 32'h0102_0304, 0, 0, 4'h4);
        step("R5", 0, 0, 8'h00, '0, 0, 0, 4'h4);

        // Mixed pattern
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = 32'h9E37_79B9 * (n + 1) ^ 32'h5A5A_1234;
            step("R2 R4 mix", r[0], (r[5:3] == 3'd0), r[15:8], r ^ 32'hC001_D00D,
                 r[1], r[2], r[19:16]);
        end

        do_clear();
        // R10: first update after release follows inputs at the next edge
        step("R10", 1, 0, 8'h5C, '0, 1, 0, 4'hB);
        step("R10", 1, 0, 8'h6D, '0, 1, 0, 4'hD);
        step("R10", 0, 0, 8'h00, '0, 0, 0, 4'h0);
        step("R10", 0, 0, 8'h00, '0, 0, 0, 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule